// File: doc/BRIEF.md
# Secure and Privileged Access Gate for an AHB Subordinate

This gate sits on the subordinate side of an AHB bus, in front of one protected target. During each address phase it combines the transfer's security attribute and privilege attribute with two address windows. The first window admits only Secure transfers. The second window admits only privileged transfers. A transfer that passes both tests reaches the downstream target unchanged, and the target's ready, response and read data are sent back upstream.

A transfer that fails a test never reaches the target. Its downstream select stays low, so a blocked write has no side effect there. The gate then answers upstream with a two-cycle ERROR response of its own. Every blocked transfer is counted in a saturating counter. The address of the first blocked transfer since reset is held for later inspection.

An upstream bus may not carry a security attribute. In that case a configuration pin chooses how the gate treats every transfer. The pin's zero value means Non-secure, so a gate with this pin left at zero never grants Secure access by accident.

Top module: `ahb_sec_filter`

## Requirements
- R1: A legal transfer passes through. `m_sel` equals `s_sel`. During its data phase, `s_readyout`, `s_resp` and `s_rdata` equal `m_readyout`, `m_resp` and `m_rdata`, and this includes downstream wait states.
- R2: An active transfer is Non-secure when `s_nsec`=1. A Non-secure active transfer whose address lies in the secure window is blocked.
- R3: A Secure transfer (`s_nsec`=0) to the secure window is not blocked, whatever its privilege.
- R4: A transfer with `s_priv`=0 (unprivileged) whose address lies in the privileged-only window is blocked. The same access with `s_priv`=1 passes.
- R5: A blocked transfer is answered with two cycles. In the first cycle `s_resp`=1 and `s_readyout`=0. In the second cycle `s_resp`=1 and `s_readyout`=1. After that the gate returns to pass-through.
- R6: `m_sel` is 0 in the address phase of a blocked transfer. It is also 0 during the first ERROR cycle, even while `s_sel`=1.
- R7: Window bounds are inclusive. `base` and `limit` are inside the window. `base-1` and `limit+1` are outside it.
- R8: When `cfg_nsec_used`=0, `s_nsec` is ignored. Every transfer is then Non-secure if `cfg_tie_secure`=0 and Secure if `cfg_tie_secure`=1.
- R9: `viol_count` grows by one for each blocked transfer. It saturates at 2^CNT_W-1 and holds that value.
- R10: On the first blocked transfer after reset, `fault_addr` captures its address and `fault_valid` rises. Later blocked transfers do not change `fault_addr`.
- R11: A transfer type of IDLE (`s_trans`=2'b00) or BUSY (2'b01) is never blocked or counted. Only NONSEQ (2'b10) and SEQ (2'b11) are checked.
- R12: After reset, `s_readyout`=1, `s_resp`=0, `viol_count`=0, `fault_valid`=0 and `fault_addr`=0.
- R13: A blocked transfer whose address phase falls in the second ERROR cycle starts a new two-cycle ERROR response straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_sel | input | 1 | Upstream select for this target |
| s_addr | input | ADDR_W | Upstream address |
| s_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| s_nsec | input | 1 | Security attribute, 1 = Non-secure |
| s_priv | input | 1 | Privilege attribute (bit 1 of the protection bundle), 1 = privileged |
| s_ready | input | 1 | Bus-wide ready, which qualifies the address phase |
| s_readyout | output | 1 | Ready returned upstream |
| s_resp | output | 1 | Response returned upstream, 1 = ERROR |
| s_rdata | output | DATA_W | Read data returned upstream |
| m_sel | output | 1 | Select to the downstream target |
| m_readyout | input | 1 | Downstream ready |
| m_resp | input | 1 | Downstream response |
| m_rdata | input | DATA_W | Downstream read data |
| cfg_nsec_used | input | 1 | 1 = `s_nsec` is driven by the upstream side |
| cfg_tie_secure | input | 1 | Tie-off value used when `cfg_nsec_used`=0, 1 = Secure |
| sec_base | input | ADDR_W | Secure window lower bound |
| sec_limit | input | ADDR_W | Secure window upper bound |
| priv_base | input | ADDR_W | Privileged-only window lower bound |
| priv_limit | input | ADDR_W | Privileged-only window upper bound |
| viol_count | output | CNT_W | Saturating count of blocked transfers |
| fault_valid | output | 1 | A fault address has been captured |
| fault_addr | output | ADDR_W | Address of the first blocked transfer |

## Verification
The bench builds the gate with ADDR_W=16, CNT_W=4 and DATA_W=32. The narrow counter saturates at 15 after a short run of blocked transfers, so R9 can be tested fully. The 16-bit address lets the vector table place probes at each window's base and limit and one step beyond each bound, on both windows. The bench also ties `s_ready` to `s_readyout`, as a single-target bus would. This lets it drive a blocked transfer during the first ERROR cycle and during the second ERROR cycle, to confirm that only the second one is accepted.

// File: rtl/ahb_sec_pkg.sv
// Shared types and constants for the AHB secure access gate.
// Assumes the standard two-bit transfer-type encoding.
package ahb_sec_pkg;

    // Response sequencer states
    typedef enum logic [1:0] {
        RSP_PASS = 2'd0,
        RSP_ERR1 = 2'd1,
        RSP_ERR2 = 2'd2
    } rsp_state_e;

    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    // Window indices used by the comparator array
    localparam int WIN_SEC  = 0;
    localparam int WIN_PRIV = 1;
    localparam int NUM_WIN  = 2;

endpackage

// File: rtl/asf_window_cmp.sv
// Inclusive address window comparator: hit when base <= addr <= limit.
// Assumes base and limit are static during operation; purely combinational.
module asf_window_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              hit
);

    // Both bounds are part of the window
    always_comb begin
        hit = (addr >= base) && (addr <= limit);
    end

endmodule

// File: rtl/asf_resp_fsm.sv
// Sequencer for the locally generated two-cycle ERROR response.
// Assumes viol is only raised for an accepted address phase (bus ready high),
// so it cannot be raised while the first ERROR cycle holds the bus.
module asf_resp_fsm
    import ahb_sec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic viol,
    output logic err_first,
    output logic err_second
);

    rsp_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_PASS: state_d = viol ? RSP_ERR1 : RSP_PASS;
            RSP_ERR1: state_d = RSP_ERR2;
            RSP_ERR2: state_d = viol ? RSP_ERR1 : RSP_PASS;
            default:  state_d = RSP_PASS;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_PASS;
        else        state_q <= state_d;
    end

    // Decoded phase flags
    always_comb begin
        err_first  = (state_q == RSP_ERR1);
        err_second = (state_q == RSP_ERR2);
    end

endmodule

// File: rtl/asf_fault_log.sv
// Violation bookkeeping: saturating counter and first-fault address capture.
// Assumes viol is a single-cycle pulse per blocked transfer.
module asf_fault_log #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Saturating violation counter
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (viol && count != CNT_MAX) count <= count + 1'b1;
    end

    // Capture the first violating address only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_addr  <= '0;
        end else if (viol && !fault_valid) begin
            fault_valid <= 1'b1;
            fault_addr  <= addr;
        end
    end

endmodule

// File: rtl/ahb_sec_filter.sv
// AHB secure access gate in front of one protected subordinate.
// Checks each active address phase against a secure-only window and a
// privileged-only window, suppresses the downstream select for illegal
// transfers and answers them with a local two-cycle ERROR response.
// Assumes s_ready is the bus-wide ready, and that the downstream target
// drives m_readyout high whenever it has no data phase in progress.
module ahb_sec_filter
    import ahb_sec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [1:0]        s_trans,
    input  logic              s_nsec,
    input  logic              s_priv,
    input  logic              s_ready,
    output logic              s_readyout,
    output logic              s_resp,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_sel,
    input  logic              m_readyout,
    input  logic              m_resp,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              cfg_nsec_used,
    input  logic              cfg_tie_secure,
    input  logic [ADDR_W-1:0] sec_base,
    input  logic [ADDR_W-1:0] sec_limit,
    input  logic [ADDR_W-1:0] priv_base,
    input  logic [ADDR_W-1:0] priv_limit,
    output logic [CNT_W-1:0]  viol_count,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_limit;
    logic [NUM_WIN-1:0]             win_hit;
    logic xfer_active, nsec_eff, illegal, viol;
    logic err_first, err_second;

    // Gather window bounds into indexed arrays
    always_comb begin
        win_base[WIN_SEC]   = sec_base;
        win_limit[WIN_SEC]  = sec_limit;
        win_base[WIN_PRIV]  = priv_base;
        win_limit[WIN_PRIV] = priv_limit;
    end

    // One comparator per window
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        asf_window_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .addr  (s_addr),
            .base  (win_base[w]),
            .limit (win_limit[w]),
            .hit   (win_hit[w])
        );
    end

    // Access decision for the current address phase
    always_comb begin
        xfer_active = (s_trans == TR_NONSEQ) || (s_trans == TR_SEQ);
        nsec_eff    = cfg_nsec_used ? s_nsec : !cfg_tie_secure;
        illegal     = xfer_active &&
                      ((nsec_eff && win_hit[WIN_SEC]) ||
                       (!s_priv && win_hit[WIN_PRIV]));
        viol        = s_sel && s_ready && illegal;
    end

    asf_resp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol       (viol),
        .err_first  (err_first),
        .err_second (err_second)
    );

    asf_fault_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .viol        (viol),
        .addr        (s_addr),
        .count       (viol_count),
        .fault_valid (fault_valid),
        .fault_addr  (fault_addr)
    );

    // Downstream select gated by the decision and the first error cycle
    always_comb begin
        m_sel = s_sel && !illegal && !err_first;
    end

    // Upstream response: local ERROR or downstream pass-through
    always_comb begin
        if (err_first) begin
            s_readyout = 1'b0;
            s_resp     = 1'b1;
            s_rdata    = '0;
        end else if (err_second) begin
            s_readyout = 1'b1;
            s_resp     = 1'b1;
            s_rdata    = '0;
        end else begin
            s_readyout = m_readyout;
            s_resp     = m_resp;
            s_rdata    = m_rdata;
        end
    end

endmodule

// File: rtl/ahb_sec_filter_chk.sv
// Property checker for ahb_sec_filter, attached through bind.
// Observes only ports of the gate.
module ahb_sec_filter_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_sel,
    input logic              s_readyout,
    input logic              s_resp,
    input logic [CNT_W-1:0]  viol_count,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_addr
);

    // R5
    err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp && !s_readyout) |=> (s_resp && s_readyout));

    // R6
    err_sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp && !s_readyout) |-> !m_sel);

    // R9
    cnt_hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_count == {CNT_W{1'b1}}) |=> (viol_count == {CNT_W{1'b1}}));

    // R9
    cnt_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_count != $past(viol_count)) |-> (s_resp && !s_readyout));

    // R10
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (fault_valid && $stable(fault_addr)));

endmodule

bind ahb_sec_filter ahb_sec_filter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .m_sel       (m_sel),
    .s_readyout  (s_readyout),
    .s_resp      (s_resp),
    .viol_count  (viol_count),
    .fault_valid (fault_valid),
    .fault_addr  (fault_addr)
);

// File: tb/ahb_sec_filter_bench.sv
module ahb_sec_filter_bench;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam logic [DW-1:0] DN_DATA = 32'hCAFE_0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_sel = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [1:0]    s_trans = 2'b00;
    logic          s_nsec = 1'b0;
    logic          s_priv = 1'b0;
    logic          s_ready;
    logic          s_readyout, s_resp, m_sel;
    logic [DW-1:0] s_rdata;
    logic          m_readyout = 1'b1;
    logic          m_resp = 1'b0;
    logic          cfg_nsec_used = 1'b1;
    logic          cfg_tie_secure = 1'b0;
    logic [CW-1:0] viol_count;
    logic          fault_valid;
    logic [AW-1:0] fault_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign s_ready = s_readyout;

    ahb_sec_filter #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_ahb_sec_filter (
        .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_addr(s_addr),
        .s_trans(s_trans), .s_nsec(s_nsec), .s_priv(s_priv), .s_ready(s_ready),
        .s_readyout(s_readyout), .s_resp(s_resp), .s_rdata(s_rdata),
        .m_sel(m_sel), .m_readyout(m_readyout), .m_resp(m_resp), .m_rdata(DN_DATA),
        .cfg_nsec_used(cfg_nsec_used), .cfg_tie_secure(cfg_tie_secure),
        .sec_base(16'h1000), .sec_limit(16'h1FFF),
        .priv_base(16'h3000), .priv_limit(16'h30FF),
        .viol_count(viol_count), .fault_valid(fault_valid), .fault_addr(fault_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        s_sel = 1'b0; s_trans = 2'b00;
    endtask

    // One transfer: address phase, then response phases
    task automatic run_xfer(input logic [AW-1:0] a, input logic ns, input logic pv,
                            input logic [1:0] tr, input logic blk, input string req);
        @(negedge clk);
        s_sel = 1'b1; s_addr = a; s_nsec = ns; s_priv = pv; s_trans = tr;
        #1 check({req, " m_sel"}, {31'd0, m_sel}, {31'd0, !blk});
        @(negedge clk);
        go_idle();
        #1;
        if (blk) begin
            check({req, " R5 err1"}, {30'd0, s_resp, s_readyout}, 32'h2);
            @(negedge clk); #1;
            check({req, " R5 err2"}, {30'd0, s_resp, s_readyout}, 32'h3);
            @(negedge clk); #1;
            check({req, " R5 after"}, {30'd0, s_resp, s_readyout}, 32'h1);
        end else begin
            check({req, " R1 resp"}, {30'd0, s_resp, s_readyout}, 32'h1);
            check({req, " R1 rdata"}, s_rdata, DN_DATA);
        end
    endtask

    // Vector: {addr, nsec, priv, trans, blocked}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {16'h0500, 1'b1, 1'b0, 2'b10, 1'b0},  // R1 outside both windows
        {16'h1800, 1'b1, 1'b1, 2'b10, 1'b1},  // R2 non-secure in secure window
        {16'h1800, 1'b0, 1'b0, 2'b11, 1'b0},  // R3 secure passes
        {16'h3050, 1'b0, 1'b0, 2'b10, 1'b1},  // R4 unprivileged blocked
        {16'h3050, 1'b1, 1'b1, 2'b10, 1'b0},  // R4 privileged passes
        {16'h1000, 1'b1, 1'b1, 2'b10, 1'b1},  // R7 base inside
        {16'h0FFF, 1'b1, 1'b1, 2'b10, 1'b0},  // R7 base-1 outside
        {16'h1FFF, 1'b1, 1'b1, 2'b11, 1'b1},  // R7 limit inside
        {16'h2000, 1'b1, 1'b1, 2'b10, 1'b0},  // R7 limit+1 outside
        {16'h30FF, 1'b0, 1'b0, 2'b10, 1'b1},  // R7 priv limit inside
        {16'h3100, 1'b0, 1'b0, 2'b10, 1'b0},  // R7 priv limit+1 outside
        {16'h1800, 1'b1, 1'b0, 2'b00, 1'b0}   // R11 IDLE never blocked
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check("R12 readyout", {31'd0, s_readyout}, 32'd1);
        check("R12 resp", {31'd0, s_resp}, 32'd0);
        check("R12 count", {28'd0, viol_count}, 32'd0);
        check("R12 fault_valid", {31'd0, fault_valid}, 32'd0);
        check("R12 fault_addr", {16'd0, fault_addr}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            run_xfer(VEC[i][20:5], VEC[i][4], VEC[i][3], VEC[i][2:1], VEC[i][0], "vec");
        check("R11 R9 count after table", {28'd0, viol_count}, 32'd5);
        check("R10 fault_valid", {31'd0, fault_valid}, 32'd1);
        check("R10 first fault addr", {16'd0, fault_addr}, 32'h1800);
        run_xfer(16'h0500, 1'b1, 1'b0, 2'b01, 1'b0, "R11 BUSY");

        // R1 downstream wait state forwarded
        @(negedge clk);
        s_sel = 1'b1; s_addr = 16'h0400; s_nsec = 1'b1; s_priv = 1'b0; s_trans = 2'b10;
        @(negedge clk);
        go_idle(); m_readyout = 1'b0;
        #1 check("R1 wait state", {30'd0, s_resp, s_readyout}, 32'h0);
        @(negedge clk); m_readyout = 1'b1;
        #1 check("R1 wait end", {30'd0, s_resp, s_readyout}, 32'h1);

        // R8 tie-off when the security attribute is absent
        cfg_nsec_used = 1'b0; cfg_tie_secure = 1'b0;
        run_xfer(16'h1800, 1'b0, 1'b1, 2'b10, 1'b1, "R8 tie non-secure");
        cfg_tie_secure = 1'b1;
        run_xfer(16'h1800, 1'b1, 1'b1, 2'b10, 1'b0, "R8 tie secure");
        cfg_nsec_used = 1'b1; cfg_tie_secure = 1'b0;

        // R13 back-to-back violations
        @(negedge clk);
        s_sel = 1'b1; s_addr = 16'h1100; s_nsec = 1'b1; s_priv = 1'b1; s_trans = 2'b10;
        @(negedge clk);
        s_addr = 16'h1200;
        #1 check("R6 m_sel in err1", {31'd0, m_sel}, 32'd0);
        check("R13 err1 a", {30'd0, s_resp, s_readyout}, 32'h2);
        @(negedge clk); #1;
        check("R13 err2 a", {30'd0, s_resp, s_readyout}, 32'h3);
        @(negedge clk);
        go_idle();
        #1 check("R13 err1 b", {30'd0, s_resp, s_readyout}, 32'h2);
        @(negedge clk); #1;
        check("R13 err2 b", {30'd0, s_resp, s_readyout}, 32'h3);
        @(negedge clk); #1;
        check("R13 pass", {30'd0, s_resp, s_readyout}, 32'h1);
        check("R9 count", {28'd0, viol_count}, 32'd8);

        // R9 saturation
        for (int k = 0; k < 10; k++)
            run_xfer(16'h1400, 1'b1, 1'b1, 2'b10, 1'b1, "R9 sat");
        check("R9 saturated", {28'd0, viol_count}, 32'd15);
        check("R10 addr kept", {16'd0, fault_addr}, 32'h1800);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule